// File: doc/BRIEF.md
# Root-Port Interrupt Collector

This block gathers the interrupt sources of one root port into a single host interrupt line. Message-signalled interrupts arrive as inbound memory writes on a valid/ready stream. A write is accepted when its 64-bit address equals a programmed target whose upper half is taken as zero, and its data names one of 32 vectors. The accepted write sets that vector's bit in a 32-bit vector status register. The four legacy INTx inputs are sampled each cycle, and a high input sets its own status bit.

Software sees a summary status word and a mask word that share one bit layout. The four INTx bits sit at 16 to 19 and a single MSI summary bit sits at 23. The MSI summary bit rises whenever any vector is recorded. To service MSI, software reads and clears the vector register until it reads zero, and only then clears the summary bit. Every status bit is cleared by writing 1 to it. The host line is high while any unmasked summary bit is set. The MSI stream applies no back-pressure outside reset: `msi_ready` is high in every cycle after reset, and a beat is consumed in the cycle in which `msi_valid` and `msi_ready` are both high. A beat that is not accepted is discarded and is never retried.

The register port is a plain single-cycle write strobe with a combinational read. Registers are selected by a 3-bit index: 0 is the summary status, 1 is the mask, 2 is the vector status and 3 is the MSI target address.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset the summary and vector status read 0, the mask reads 0x008F0000 (all sources masked), the target reads 0 and `irq_out` is low.
- R2: An accepted MSI beat whose data N is less than 32 and whose address matches sets vector bit N and summary bit 23 on the next clock edge. Beats with different data accumulate in the vector register.
- R3: Writing the vector register (index 2) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: An MSI beat is dropped and changes no state if its data is 32 or more, if `msi_addr[31:0]` differs from the target, or if `msi_addr[63:32]` is not zero.
- R5: INTx input k (A=0 to D=3) sets summary bit 16+k in every cycle it is high. Writing 1 to that bit clears it only once the input is low.
- R6: Mask bits 16 to 19 and 23 (1 = masked) gate the matching summary bits. `irq_out` is the OR of all unmasked summary bits.
- R7: When a status bit is set and cleared by a write of 1 in the same cycle, the set takes effect. This holds for the vector bits and for the MSI summary bit.
- R8: The MSI summary bit stays set after the vector register has been drained, and is cleared only by writing 1 to bit 23 of index 0.
- R9: `msi_ready` is low in reset and high in every cycle after it.
- R10: The target (index 3) reads back the value written. Indices 4 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound MSI write beat present |
| msi_ready | output | 1 | Beat is accepted this cycle |
| msi_addr | input | 64 | Beat address |
| msi_data | input | 32 | Beat data (vector number) |
| intx_in | input | 4 | Legacy INTx A..D, high = asserted |
| csr_wen | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Aggregated host interrupt |

## Verification
The assertions assume that `intx_in` and every MSI field are synchronous to `clk` and stable across each sampling edge. They also assume that at most one MSI beat and one register write occur per cycle, so the only thing that can change a vector bit is an accepted beat or a clear of that register. The bench drives all inputs on the falling edge and holds each beat or write for exactly one rising edge. It creates same-cycle set/clear collisions only on purpose, by driving both in one task.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CSR_IDX_W = 3;

  typedef enum logic [CSR_IDX_W-1:0] {
    CSR_SUMMARY = 3'd0,
    CSR_MASK    = 3'd1,
    CSR_VECTOR  = 3'd2,
    CSR_TARGET  = 3'd3
  } csr_idx_e;
endpackage

// File: rtl/msi_decoder.sv
module msi_decoder #(
  parameter int NUM_VEC = 32,
  parameter int TGT_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic                msi_valid,
  input  logic                msi_ready,
  input  logic [2*TGT_W-1:0]  msi_addr,
  input  logic [DATA_W-1:0]   msi_data,
  input  logic [TGT_W-1:0]    target,
  output logic                hit,
  output logic [NUM_VEC-1:0]  set_vec
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic addr_ok;
  logic data_ok;

  // Upper address half must be zero; lower half must equal the target.
  assign addr_ok = (msi_addr[2*TGT_W-1:TGT_W] == '0) && (msi_addr[TGT_W-1:0] == target);
  assign data_ok = (msi_data < DATA_W'(NUM_VEC));
  assign hit     = msi_valid && msi_ready && addr_ok && data_ok;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
    assign set_vec[i] = hit && (msi_data[VEC_W-1:0] == VEC_W'(i));
  end
endmodule

// File: rtl/w1c_bank.sv
module w1c_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_bits,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                     q[i] <= 1'b0;
      else if (set_bits[i])           q[i] <= 1'b1;   // set wins over clear
      else if (clr_en && clr_bits[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_VEC     = 32,
  parameter int NUM_INTX    = 4,
  parameter int REG_W       = 32,
  parameter int TGT_W       = 32,
  parameter int INTX_LSB    = 16,
  parameter int MSI_SUM_POS = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msi_valid,
  output logic                  msi_ready,
  input  logic [2*TGT_W-1:0]    msi_addr,
  input  logic [REG_W-1:0]      msi_data,
  input  logic [NUM_INTX-1:0]   intx_in,
  input  logic                  csr_wen,
  input  logic [CSR_IDX_W-1:0]  csr_addr,
  input  logic [REG_W-1:0]      csr_wdata,
  output logic [REG_W-1:0]      csr_rdata,
  output logic                  irq_out
);
  logic                rdy_q;
  logic [TGT_W-1:0]    target_q;
  logic [NUM_INTX-1:0] mask_intx_q;
  logic                mask_msi_q;
  logic                msi_hit;
  logic [NUM_VEC-1:0]  vec_set;
  logic [NUM_VEC-1:0]  vec_q;
  logic [NUM_INTX-1:0] intx_stat;
  logic [0:0]          msi_sum_q;
  logic                wr_sum;
  logic                wr_mask;
  logic                wr_vec;
  logic                wr_tgt;
  logic [REG_W-1:0]    sum_word;
  logic [REG_W-1:0]    mask_word;
  logic [REG_W-1:0]    vec_word;

  assign wr_sum  = csr_wen && (csr_addr == CSR_SUMMARY);
  assign wr_mask = csr_wen && (csr_addr == CSR_MASK);
  assign wr_vec  = csr_wen && (csr_addr == CSR_VECTOR);
  assign wr_tgt  = csr_wen && (csr_addr == CSR_TARGET);

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign msi_ready = rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q    <= '0;
      mask_intx_q <= '1;
      mask_msi_q  <= 1'b1;
    end else begin
      if (wr_tgt) target_q <= csr_wdata[TGT_W-1:0];
      if (wr_mask) begin
        mask_intx_q <= csr_wdata[INTX_LSB +: NUM_INTX];
        mask_msi_q  <= csr_wdata[MSI_SUM_POS];
      end
    end
  end

  msi_decoder #(.NUM_VEC(NUM_VEC), .TGT_W(TGT_W), .DATA_W(REG_W)) u_dec (
    .msi_valid (msi_valid),
    .msi_ready (msi_ready),
    .msi_addr  (msi_addr),
    .msi_data  (msi_data),
    .target    (target_q),
    .hit       (msi_hit),
    .set_vec   (vec_set)
  );

  w1c_bank #(.WIDTH(NUM_VEC)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (vec_set),
    .clr_en   (wr_vec),
    .clr_bits (csr_wdata[NUM_VEC-1:0]),
    .q        (vec_q)
  );

  w1c_bank #(.WIDTH(NUM_INTX)) u_intx (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (intx_in),
    .clr_en   (wr_sum),
    .clr_bits (csr_wdata[INTX_LSB +: NUM_INTX]),
    .q        (intx_stat)
  );

  w1c_bank #(.WIDTH(1)) u_msum (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (msi_hit),
    .clr_en   (wr_sum),
    .clr_bits (csr_wdata[MSI_SUM_POS]),
    .q        (msi_sum_q)
  );

  always_comb begin
    sum_word = '0;
    sum_word[INTX_LSB +: NUM_INTX] = intx_stat;
    sum_word[MSI_SUM_POS]          = msi_sum_q[0];
    mask_word = '0;
    mask_word[INTX_LSB +: NUM_INTX] = mask_intx_q;
    mask_word[MSI_SUM_POS]          = mask_msi_q;
    vec_word = '0;
    vec_word[NUM_VEC-1:0] = vec_q;
  end

  always_comb begin
    case (csr_addr)
      CSR_SUMMARY: csr_rdata = sum_word;
      CSR_MASK:    csr_rdata = mask_word;
      CSR_VECTOR:  csr_rdata = vec_word;
      CSR_TARGET:  csr_rdata = REG_W'(target_q);
      default:     csr_rdata = '0;
    endcase
  end

  assign irq_out = (|(intx_stat & ~mask_intx_q)) || (msi_sum_q[0] && !mask_msi_q);
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_VEC     = 32,
  parameter int NUM_INTX    = 4,
  parameter int REG_W       = 32,
  parameter int TGT_W       = 32,
  parameter int MSI_SUM_POS = 23
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msi_valid,
  input logic                msi_ready,
  input logic [2*TGT_W-1:0]  msi_addr,
  input logic [REG_W-1:0]    msi_data,
  input logic [NUM_INTX-1:0] intx_in,
  input logic                csr_wen,
  input logic [2:0]          csr_addr,
  input logic [REG_W-1:0]    csr_wdata,
  input logic                irq_out,
  input logic [TGT_W-1:0]    target_q,
  input logic [NUM_VEC-1:0]  vec_q,
  input logic [NUM_INTX-1:0] intx_stat,
  input logic [0:0]          msi_sum_q
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic beat_ok;
  logic vec_clr;
  logic sum_clr;
  assign beat_ok = msi_valid && msi_ready && (msi_addr == {{TGT_W{1'b0}}, target_q})
                   && (msi_data < REG_W'(NUM_VEC));
  assign vec_clr = csr_wen && (csr_addr == 3'd2);
  assign sum_clr = csr_wen && (csr_addr == 3'd0) && csr_wdata[MSI_SUM_POS];

  // R2 and R7: an accepted beat leaves its vector bit set
  p_vec_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok |=> vec_q[$past(msi_data[VEC_W-1:0])]);

  // R7: summary bit set after accepted beat, even against a clear
  p_sum_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok |=> msi_sum_q[0]);

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_ok && !vec_clr) |=> $stable(vec_q));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_clr && !beat_ok) |=> ((vec_q & $past(csr_wdata[NUM_VEC-1:0])) == '0));

  p_sum_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_clr && !beat_ok) |=> !msi_sum_q[0]);

  p_intx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_in != '0) |=> ((intx_stat & $past(intx_in)) == $past(intx_in)));

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((intx_stat != '0) || msi_sum_q[0]));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> msi_ready);
endmodule

bind pcie_irq_agg irq_agg_checker #(
  .NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX), .REG_W(REG_W), .TGT_W(TGT_W), .MSI_SUM_POS(MSI_SUM_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_valid (msi_valid),
  .msi_ready (msi_ready),
  .msi_addr  (msi_addr),
  .msi_data  (msi_data),
  .intx_in   (intx_in),
  .csr_wen   (csr_wen),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .irq_out   (irq_out),
  .target_q  (target_q),
  .vec_q     (vec_q),
  .intx_stat (intx_stat),
  .msi_sum_q (msi_sum_q)
);

// File: tb/pcie_irq_agg_tb.sv
module pcie_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic [3:0]  intx_in = '0;
  logic        csr_wen = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  localparam logic [31:0] TGT = 32'h1000_0040;

  always #4 clk = ~clk;

  pcie_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data), .intx_in(intx_in),
    .csr_wen(csr_wen), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    csr_addr = idx;
    #1;
    v = csr_rdata;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    csr_wen = 1'b1; csr_addr = idx; csr_wdata = d;
    @(negedge clk);
    csr_wen = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); chk("R1 summary", v, 32'h0);
    rd(3'd1, v); chk("R1 mask", v, 32'h008F_0000);
    rd(3'd2, v); chk("R1 vector", v, 32'h0);
    rd(3'd3, v); chk("R1 target", v, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R9 ready", {31'b0, msi_ready}, 32'h1);
  endtask

  task automatic t_target;
    logic [31:0] v;
    wr(3'd3, TGT);
    rd(3'd3, v); chk("R10 target readback", v, TGT);
  endtask

  task automatic t_msi_basic;
    logic [31:0] v;
    msi({32'h0, TGT}, 32'd5);
    rd(3'd2, v); chk("R2 vector 5", v, 32'h0000_0020);
    rd(3'd0, v); chk("R2 summary bit23", v, 32'h0080_0000);
    chk("R6 masked irq", {31'b0, irq_out}, 32'h0);
    msi({32'h0, TGT}, 32'd31);
    msi({32'h0, TGT}, 32'd0);
    rd(3'd2, v); chk("R2 accumulate", v, 32'h8000_0021);
  endtask

  task automatic t_unmask;
    wr(3'd1, 32'h000F_0000);
    #1 chk("R6 unmask msi irq", {31'b0, irq_out}, 32'h1);
    wr(3'd1, 32'h008F_0000);
    #1 chk("R6 remask irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_drop;
    logic [31:0] v;
    msi({32'h0, TGT}, 32'd32);
    msi({32'h0, TGT}, 32'd100);
    msi({32'h0, TGT + 32'd4}, 32'd3);
    msi({32'h1, TGT}, 32'd3);
    rd(3'd2, v); chk("R4 dropped beats", v, 32'h8000_0021);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd2, 32'h0000_0020);
    rd(3'd2, v); chk("R3 clear bit5", v, 32'h8000_0001);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R3 zero write", v, 32'h8000_0001);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_drain;
    logic [31:0] v;
    rd(3'd0, v); chk("R8 summary after drain", v, 32'h0080_0000);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R8 zero write kept", v, 32'h0080_0000);
    wr(3'd0, 32'h0080_0000);
    rd(3'd0, v); chk("R8 summary cleared", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    msi({32'h0, TGT}, 32'd7);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = {32'h0, TGT}; msi_data = 32'd7;
    csr_wen = 1'b1; csr_addr = 3'd2; csr_wdata = 32'h0000_0080;
    @(negedge clk);
    msi_valid = 1'b0; csr_wen = 1'b0;
    rd(3'd2, v); chk("R7 vector set wins", v, 32'h0000_0080);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = 32'd9;
    csr_wen = 1'b1; csr_addr = 3'd0; csr_wdata = 32'h0080_0000;
    @(negedge clk);
    msi_valid = 1'b0; csr_wen = 1'b0;
    rd(3'd0, v); chk("R7 summary set wins", v, 32'h0080_0000);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0080_0000);
  endtask

  task automatic t_intx;
    logic [31:0] v;
    @(negedge clk); intx_in = 4'b0010;
    @(negedge clk);
    rd(3'd0, v); chk("R5 intx B bit17", v, 32'h0002_0000);
    chk("R6 intx masked", {31'b0, irq_out}, 32'h0);
    wr(3'd1, 32'h008D_0000);
    #1 chk("R6 intx unmasked irq", {31'b0, irq_out}, 32'h1);
    wr(3'd0, 32'h0002_0000);
    rd(3'd0, v); chk("R5 clear while held", v, 32'h0002_0000);
    @(negedge clk); intx_in = 4'b0000;
    wr(3'd0, 32'h0002_0000);
    rd(3'd0, v); chk("R5 cleared", v, 32'h0);
    chk("R6 irq dropped", {31'b0, irq_out}, 32'h0);
    @(negedge clk); intx_in = 4'b1000;
    @(negedge clk); intx_in = 4'b0000;
    rd(3'd0, v); chk("R5 intx D pulse bit19", v, 32'h0008_0000);
    wr(3'd0, 32'h000F_0000);
  endtask

  task automatic t_unused;
    logic [31:0] v;
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R10 unused index reads 0", v, 32'h0);
    rd(3'd1, v); chk("R10 mask untouched", v, 32'h008D_0000);
    rd(3'd3, v); chk("R10 target untouched", v, TGT);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_target();
    t_msi_basic();
    t_unmask();
    t_drop();
    t_w1c();
    t_drain();
    t_collide();
    t_intx();
    t_unused();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end
endmodule